// File: doc/BRIEF.md
# Delayed-Branch Program Counter Sequencer

This block steers the program counter of a small in-order processor with a two-step pipeline: one instruction is fetched while the one before it executes. Each cycle the decoder presents the control-transfer kind of the executing instruction. Alongside it come a condition selector, a signed offset, a register-held target, the return-address register value and the N, Z, V and C flags. The block returns the next fetch address, the address and validity of the executing instruction, and a marker that says the executing instruction sits in a delay slot. It also produces a link-write strobe with the return address for calls, and a pulse that reports an illegal control transfer placed in a slot.

Every transfer comes in two forms. A non-delayed taken transfer discards the instruction fetched behind it, which leaves one bubble. A delayed transfer always lets that next instruction (the slot) run first, whether or not the branch is taken, and only then executes the target. Only the order of PC updates changes. Register effects stay in program order, so the decision uses the flags as they stand in the branch's own execute cycle.

The sequencer has three states. FILL means the execute step is empty, after reset or after a squash. RUN means an ordinary instruction is executing. SLOT means a delay-slot instruction is executing. FILL always moves to RUN. RUN moves to FILL on a non-delayed taken transfer, to SLOT on any legal delayed transfer, and otherwise stays in RUN. SLOT always moves to RUN.

Top module: `dslot_pc_seq`

## Requirements
- R1: While reset is held and right after it is released, fetch_addr equals RESET_VEC (default 0x100) and exec_valid, delay_slot, illegal_slot and link_we are 0. In the following cycle the instruction at RESET_VEC executes.
- R2: Instruction size is INSN_BYTES (default 2). When exec_valid is 1 and the kind is none (code 0) or reserved (code 7), the next fetch_addr is fetch_addr+2 and the next exec_pc is the current fetch_addr.
- R3: The transfer target depends on the kind. For kind 1 (branch), 2 (conditional) and 4 (relative call) it is exec_pc plus the sign-extended OFF_W-bit offset. For kind 3 (register jump) and 5 (register call) it is reg_target. For kind 6 (return) it is ret_addr.
- R4: A taken non-delayed transfer (ct_delayed=0) puts the target on fetch_addr in the next cycle with exec_valid=0. The target executes one cycle later.
- R5: A delayed transfer (ct_delayed=1) executed outside a slot is followed in the next cycle by the instruction at its address+2, with delay_slot=1 and no bubble. When the transfer is taken, the target is fetched in that same cycle and executes right after the slot.
- R6: A delayed conditional branch whose condition fails still runs its slot with delay_slot=1, and execution then falls through to address+4.
- R7: The condition is selected by cc_sel, with flags = {N,Z,V,C}. The codes are 0 always, 1 never, 2 Z, 3 !Z, 4 C, 5 !C, 6 N, 7 !N, 8 V, 9 !V, 10 N^V, 11 !(N^V), 12 (N^V)|Z, 13 !((N^V)|Z), 14 C|Z, 15 !(C|Z). A non-delayed conditional branch whose condition fails continues sequentially with no bubble.
- R8: The branch decision uses only the flags present in the branch's execute cycle. The flag values during the slot do not change where execution goes.
- R9: A legal call raises link_we in its execute cycle. link_addr is exec_pc+2 for a non-delayed call and exec_pc+4 for a delayed call.
- R10: A control-transfer kind executed while delay_slot=1 raises illegal_slot. It causes no redirect and no link write, and execution continues sequentially in state RUN.
- R11: While exec_valid is 0, all decode, flag and target inputs are ignored, and fetching continues sequentially.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ct_kind | input | 3 | Control-transfer kind of the executing instruction |
| ct_delayed | input | 1 | 1 selects the delayed form |
| cc_sel | input | 4 | Condition selector for conditional branches |
| flags | input | 4 | Condition flags {N,Z,V,C} |
| br_offset | input | OFF_W | Signed byte offset for relative targets |
| reg_target | input | AW | Register value for register jumps and calls |
| ret_addr | input | AW | Return-address register value |
| fetch_addr | output | AW | Address fetched this cycle |
| exec_pc | output | AW | Address of the executing instruction |
| exec_valid | output | 1 | Execute step holds an instruction |
| delay_slot | output | 1 | Executing instruction occupies a delay slot |
| illegal_slot | output | 1 | Control transfer found in a delay slot |
| link_we | output | 1 | Write return address (call executing) |
| link_addr | output | AW | Return address to store |

## Verification
The hardest situations to reach are those that combine the slot with another event. Examples are a control transfer placed inside a slot, a slot that follows a conditional branch that failed, and flags that change between the branch cycle and its slot. Directed sequences build each of these on purpose. In the R8 case, the bench drives flags that would reverse the decision during the slot cycle. A long run of random kinds, delayed bits and flags then pairs transfers back to back. Squashes, slots and illegal slots therefore meet in many orders, and a bench reference model predicts the fetch and execute stream for every one of them.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

    typedef enum logic [2:0] {
        CT_NONE     = 3'd0,
        CT_BRA      = 3'd1,
        CT_BCOND    = 3'd2,
        CT_JREG     = 3'd3,
        CT_CALL_REL = 3'd4,
        CT_CALL_REG = 3'd5,
        CT_RET      = 3'd6,
        CT_RSVD     = 3'd7
    } ct_kind_e;

    typedef enum logic [3:0] {
        CC_ALWAYS = 4'd0,
        CC_NEVER  = 4'd1,
        CC_ZS     = 4'd2,
        CC_ZC     = 4'd3,
        CC_CS     = 4'd4,
        CC_CC     = 4'd5,
        CC_NS     = 4'd6,
        CC_NC     = 4'd7,
        CC_VS     = 4'd8,
        CC_VC     = 4'd9,
        CC_SLT    = 4'd10,
        CC_SGE    = 4'd11,
        CC_SLE    = 4'd12,
        CC_SGT    = 4'd13,
        CC_ULE    = 4'd14,
        CC_UGT    = 4'd15
    } cc_e;

    typedef enum logic [1:0] {
        ST_FILL = 2'd0,
        ST_RUN  = 2'd1,
        ST_SLOT = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flag_bits_t;

endpackage

// File: rtl/dbs_cond_eval.sv
module dbs_cond_eval
    import dbs_pkg::*;
(
    input  logic [3:0] sel,
    input  logic [3:0] flags,
    output logic       pass
);
    flag_bits_t f;
    logic       lt_s;
    logic       le_s;
    logic       le_u;

    assign f    = flag_bits_t'(flags);
    assign lt_s = f.n ^ f.v;
    assign le_s = lt_s | f.z;
    assign le_u = f.c | f.z;

    always_comb begin
        unique case (cc_e'(sel))
            CC_ALWAYS: pass = 1'b1;
            CC_NEVER:  pass = 1'b0;
            CC_ZS:     pass = f.z;
            CC_ZC:     pass = ~f.z;
            CC_CS:     pass = f.c;
            CC_CC:     pass = ~f.c;
            CC_NS:     pass = f.n;
            CC_NC:     pass = ~f.n;
            CC_VS:     pass = f.v;
            CC_VC:     pass = ~f.v;
            CC_SLT:    pass = lt_s;
            CC_SGE:    pass = ~lt_s;
            CC_SLE:    pass = le_s;
            CC_SGT:    pass = ~le_s;
            CC_ULE:    pass = le_u;
            CC_UGT:    pass = ~le_u;
            default:   pass = 1'b0;
        endcase
    end
endmodule

// File: rtl/dbs_target_gen.sv
module dbs_target_gen
    import dbs_pkg::*;
#(
    parameter int AW         = 32,
    parameter int OFF_W      = 16,
    parameter int INSN_BYTES = 2
) (
    input  logic [2:0]      kind,
    input  logic            delayed,
    input  logic [AW-1:0]   pc,
    input  logic [OFF_W-1:0] offset,
    input  logic [AW-1:0]   reg_target,
    input  logic [AW-1:0]   ret_addr,
    output logic [AW-1:0]   target,
    output logic [AW-1:0]   link
);
    localparam logic [AW-1:0] STEP1 = AW'(INSN_BYTES);
    localparam logic [AW-1:0] STEP2 = AW'(2 * INSN_BYTES);

    logic [AW-1:0] off_ext;

    generate
        if (AW > OFF_W) begin : g_sext
            assign off_ext = {{(AW-OFF_W){offset[OFF_W-1]}}, offset};
        end else begin : g_trunc
            assign off_ext = offset[AW-1:0];
        end
    endgenerate

    always_comb begin
        unique case (ct_kind_e'(kind))
            CT_BRA, CT_BCOND, CT_CALL_REL: target = pc + off_ext;
            CT_JREG, CT_CALL_REG:          target = reg_target;
            CT_RET:                        target = ret_addr;
            default:                       target = pc + STEP1;
        endcase
    end

    // A delayed call returns past its slot instruction.
    assign link = pc + (delayed ? STEP2 : STEP1);
endmodule

// File: rtl/dslot_pc_seq.sv
module dslot_pc_seq
    import dbs_pkg::*;
#(
    parameter int              AW         = 32,
    parameter int              OFF_W      = 16,
    parameter int              INSN_BYTES = 2,
    parameter logic [AW-1:0]   RESET_VEC  = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        ct_kind,
    input  logic              ct_delayed,
    input  logic [3:0]        cc_sel,
    input  logic [3:0]        flags,
    input  logic [OFF_W-1:0]  br_offset,
    input  logic [AW-1:0]     reg_target,
    input  logic [AW-1:0]     ret_addr,
    output logic [AW-1:0]     fetch_addr,
    output logic [AW-1:0]     exec_pc,
    output logic              exec_valid,
    output logic              delay_slot,
    output logic              illegal_slot,
    output logic              link_we,
    output logic [AW-1:0]     link_addr
);
    localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

    seq_state_e    st_q, st_d;
    logic [AW-1:0] pcf_q, pcf_d;
    logic [AW-1:0] pce_q, pce_d;

    ct_kind_e      kind;
    logic          is_ctrl;
    logic          is_call;
    logic          legal;
    logic          taken;
    logic          cond_pass;
    logic [AW-1:0] target;
    logic [AW-1:0] link_val;

    assign kind    = ct_kind_e'(ct_kind);
    assign is_ctrl = (kind != CT_NONE) && (kind != CT_RSVD);
    assign is_call = (kind == CT_CALL_REL) || (kind == CT_CALL_REG);
    assign legal   = (st_q == ST_RUN) && is_ctrl;
    assign taken   = legal && ((kind != CT_BCOND) || cond_pass);

    dbs_cond_eval u_cond (
        .sel   (cc_sel),
        .flags (flags),
        .pass  (cond_pass)
    );

    dbs_target_gen #(
        .AW         (AW),
        .OFF_W      (OFF_W),
        .INSN_BYTES (INSN_BYTES)
    ) u_tgt (
        .kind       (ct_kind),
        .delayed    (ct_delayed),
        .pc         (pce_q),
        .offset     (br_offset),
        .reg_target (reg_target),
        .ret_addr   (ret_addr),
        .target     (target),
        .link       (link_val)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_FILL;
            pcf_q <= RESET_VEC;
            pce_q <= RESET_VEC;
        end else begin
            st_q  <= st_d;
            pcf_q <= pcf_d;
            pce_q <= pce_d;
        end
    end

    // Next-state logic
    always_comb begin
        st_d  = ST_RUN;
        pcf_d = pcf_q + STEP;
        pce_d = pcf_q;
        unique case (st_q)
            ST_FILL: begin
                st_d = ST_RUN;
            end
            ST_RUN: begin
                if (taken && !ct_delayed) begin
                    // squash the instruction fetched behind the branch
                    st_d  = ST_FILL;
                    pcf_d = target;
                    pce_d = pce_q;
                end else if (legal && ct_delayed) begin
                    st_d  = ST_SLOT;
                    pcf_d = taken ? target : (pcf_q + STEP);
                end else begin
                    st_d = ST_RUN;
                end
            end
            ST_SLOT: begin
                // a transfer here is reported, never followed
                st_d = ST_RUN;
            end
            default: begin
                st_d = ST_FILL;
            end
        endcase
    end

    // Outputs
    always_comb begin
        fetch_addr   = pcf_q;
        exec_pc      = pce_q;
        exec_valid   = (st_q != ST_FILL);
        delay_slot   = (st_q == ST_SLOT);
        illegal_slot = (st_q == ST_SLOT) && is_ctrl;
        link_we      = legal && is_call;
        link_addr    = link_val;
    end
endmodule

// File: rtl/dbs_pc_seq_chk.sv
module dbs_pc_seq_chk #(
    parameter int AW         = 32,
    parameter int OFF_W      = 16,
    parameter int INSN_BYTES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        ct_kind,
    input logic              ct_delayed,
    input logic [AW-1:0]     ret_addr,
    input logic [AW-1:0]     fetch_addr,
    input logic [AW-1:0]     exec_pc,
    input logic              exec_valid,
    input logic              delay_slot,
    input logic              illegal_slot,
    input logic              link_we,
    input logic [AW-1:0]     link_addr
);
    localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

    logic ctrl_k;
    logic uncond_k;
    logic legal_c;

    assign ctrl_k   = (ct_kind != 3'd0) && (ct_kind != 3'd7);
    assign uncond_k = ctrl_k && (ct_kind != 3'd2);
    assign legal_c  = exec_valid && !delay_slot && ctrl_k;

    // R1
    refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_valid |=> exec_valid && (exec_pc == $past(fetch_addr)));

    // R4
    squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (legal_c && uncond_k && !ct_delayed) |=> !exec_valid);

    // R5
    slot_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (legal_c && ct_delayed) |=> delay_slot && exec_valid && (exec_pc == $past(fetch_addr)));

    // R3
    ret_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (legal_c && ct_delayed && ct_kind == 3'd6) |=> fetch_addr == $past(ret_addr));

    // R10
    no_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_slot |=> exec_valid && !delay_slot && (fetch_addr == $past(fetch_addr) + STEP));

    // R10
    no_link_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_slot |-> !link_we);

    // R9
    link_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_we && ct_delayed) |-> link_addr == exec_pc + STEP + STEP);
endmodule

bind dslot_pc_seq dbs_pc_seq_chk #(
    .AW         (AW),
    .OFF_W      (OFF_W),
    .INSN_BYTES (INSN_BYTES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ct_kind      (ct_kind),
    .ct_delayed   (ct_delayed),
    .ret_addr     (ret_addr),
    .fetch_addr   (fetch_addr),
    .exec_pc      (exec_pc),
    .exec_valid   (exec_valid),
    .delay_slot   (delay_slot),
    .illegal_slot (illegal_slot),
    .link_we      (link_we),
    .link_addr    (link_addr)
);

// File: tb/sim_dslot_pc_seq.sv
`timescale 1ns/1ps
module sim_dslot_pc_seq;
    localparam logic [31:0] RV = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ct_kind = '0;
    logic        ct_delayed = 1'b0;
    logic [3:0]  cc_sel = '0;
    logic [3:0]  flags = '0;
    logic [15:0] br_offset = '0;
    logic [31:0] reg_target = '0;
    logic [31:0] ret_addr = '0;
    logic [31:0] fetch_addr, exec_pc, link_addr;
    logic        exec_valid, delay_slot, illegal_slot, link_we;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state
    logic [31:0] m_fetch, m_exec;
    logic        m_valid, m_slot;

    always #2.5 clk = ~clk;

    dslot_pc_seq u0 (
        .clk(clk), .rst_n(rst_n), .ct_kind(ct_kind), .ct_delayed(ct_delayed),
        .cc_sel(cc_sel), .flags(flags), .br_offset(br_offset),
        .reg_target(reg_target), .ret_addr(ret_addr),
        .fetch_addr(fetch_addr), .exec_pc(exec_pc), .exec_valid(exec_valid),
        .delay_slot(delay_slot), .illegal_slot(illegal_slot),
        .link_we(link_we), .link_addr(link_addr)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // flags = {N,Z,V,C}
    function automatic bit cond_ok(input logic [3:0] cs, input logic [3:0] fl);
        bit n, z, v, c;
        n = fl[3]; z = fl[2]; v = fl[1]; c = fl[0];
        case (cs)
            4'd0:  return 1;
            4'd1:  return 0;
            4'd2:  return z;
            4'd3:  return !z;
            4'd4:  return c;
            4'd5:  return !c;
            4'd6:  return n;
            4'd7:  return !n;
            4'd8:  return v;
            4'd9:  return !v;
            4'd10: return n != v;
            4'd11: return n == v;
            4'd12: return (n != v) || z;
            4'd13: return !((n != v) || z);
            4'd14: return c || z;
            default: return !(c || z);
        endcase
    endfunction

    function automatic logic [31:0] tgt_of(input logic [2:0] k, input logic [31:0] epc,
                                          input logic [15:0] off, input logic [31:0] rv,
                                          input logic [31:0] ra);
        if (k == 3'd3 || k == 3'd5) return rv;
        if (k == 3'd6) return ra;
        return epc + {{16{off[15]}}, off};
    endfunction

    task automatic step(input string tag, input logic [2:0] k, input logic d,
                        input logic [3:0] cs, input logic [3:0] fl, input logic [15:0] off,
                        input logic [31:0] rv, input logic [31:0] ra);
        bit ctrl, legal, tk, ill, lw;
        logic [31:0] tgt;
        chk(tag, "fetch_addr", fetch_addr, m_fetch);
        chk(tag, "exec_valid", 32'(exec_valid), 32'(m_valid));
        chk(tag, "delay_slot", 32'(delay_slot), 32'(m_slot));
        if (m_valid) chk(tag, "exec_pc", exec_pc, m_exec);
        ct_kind = k; ct_delayed = d; cc_sel = cs; flags = fl;
        br_offset = off; reg_target = rv; ret_addr = ra;
        #0.5;
        ctrl  = (k != 3'd0) && (k != 3'd7);
        legal = m_valid && !m_slot && ctrl;
        ill   = m_valid && m_slot && ctrl;
        tk    = legal && ((k != 3'd2) || cond_ok(cs, fl));
        lw    = legal && (k == 3'd4 || k == 3'd5);
        tgt   = tgt_of(k, m_exec, off, rv, ra);
        chk(tag, "illegal_slot", 32'(illegal_slot), 32'(ill));
        chk(tag, "link_we", 32'(link_we), 32'(lw));
        if (lw) chk(tag, "link_addr", link_addr, m_exec + (d ? 32'd4 : 32'd2));
        if (!m_valid) begin
            m_exec = m_fetch; m_fetch = m_fetch + 2; m_valid = 1; m_slot = 0;
        end else if (tk && !d) begin
            m_fetch = tgt; m_valid = 0; m_slot = 0;
        end else begin
            m_exec  = m_fetch;
            m_fetch = (tk && d) ? tgt : m_fetch + 2;
            m_slot  = legal && d;
        end
        @(negedge clk);
    endtask

    task automatic nop(input string tag);
        step(tag, 3'd0, 1'b0, 4'd0, 4'd0, 16'd0, 32'd0, 32'd0);
    endtask

    task automatic settle();
        while (!(m_valid && !m_slot)) nop("R2");
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        void'($urandom(32'd2024));
        m_fetch = RV; m_exec = RV; m_valid = 0; m_slot = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "fetch_addr", fetch_addr, RV);
        chk("R1", "exec_valid", 32'(exec_valid), 32'd0);
        chk("R1", "delay_slot", 32'(delay_slot), 32'd0);
        chk("R1", "link_we", 32'(link_we), 32'd0);
        rst_n = 1'b1;
        // R11: junk while execute is empty
        step("R11", 3'd1, 1'b0, 4'd0, 4'hF, 16'h0040, 32'h9000, 32'h9000);
        chk("R1", "exec_pc", exec_pc, RV);
        nop("R2"); nop("R2");
        // R4 non-delayed taken branch, bubble
        step("R4", 3'd1, 1'b0, 4'd0, 4'd0, 16'h0040, 32'd0, 32'd0);
        step("R4", 3'd6, 1'b1, 4'd0, 4'd0, 16'd0, 32'd0, 32'h7777_0000);
        nop("R4"); nop("R4");
        // R5 delayed taken branch with negative offset
        step("R5", 3'd1, 1'b1, 4'd0, 4'd0, 16'hFFF0, 32'd0, 32'd0);
        nop("R5"); nop("R5"); nop("R5");
        // R6 delayed conditional that fails
        step("R6", 3'd2, 1'b1, 4'd1, 4'd0, 16'h0100, 32'd0, 32'd0);
        nop("R6"); nop("R6"); nop("R6");
        // R7 non-delayed conditional that fails: no bubble
        step("R7", 3'd2, 1'b0, 4'd2, 4'b0000, 16'h0100, 32'd0, 32'd0);
        nop("R7");
        // R8 flags change during slot must not change the decision
        step("R8", 3'd2, 1'b1, 4'd2, 4'b0100, 16'h0080, 32'd0, 32'd0);
        step("R8", 3'd0, 1'b0, 4'd2, 4'b0000, 16'd0, 32'd0, 32'd0);
        nop("R8"); nop("R8");
        // R9 delayed call with a branch in its slot (R10)
        step("R9", 3'd4, 1'b1, 4'd0, 4'd0, 16'h0200, 32'd0, 32'd0);
        step("R10", 3'd1, 1'b0, 4'd0, 4'd0, 16'h0400, 32'd0, 32'd0);
        step("R10", 3'd5, 1'b1, 4'd0, 4'd0, 16'd0, 32'h0000_5000, 32'd0);
        nop("R10"); nop("R10");
        // R9 non-delayed register call, R3 register jump, delayed return
        step("R9", 3'd5, 1'b0, 4'd0, 4'd0, 16'd0, 32'h0000_3000, 32'd0);
        nop("R9"); nop("R9");
        step("R3", 3'd3, 1'b1, 4'd0, 4'd0, 16'd0, 32'h0000_6000, 32'd0);
        step("R3", 3'd7, 1'b0, 4'd0, 4'd0, 16'd0, 32'd0, 32'd0);
        nop("R3");
        step("R3", 3'd6, 1'b1, 4'd0, 4'd0, 16'd0, 32'd0, 32'h0000_0A00);
        nop("R3"); nop("R3"); nop("R3");
        // R7 full condition table
        for (int cs = 0; cs < 16; cs++) begin
            for (int fl = 0; fl < 16; fl++) begin
                settle();
                step("R7", 3'd2, 1'b0, 4'(cs), 4'(fl), 16'h0020, 32'd0, 32'd0);
                nop("R7");
            end
        end
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] k;
            logic [31:0] r;
            r = $urandom;
            k = 3'(r[2:0]);
            if (r[4:3] != 2'b00) k = 3'd0;
            step("R5", k, r[5], 4'(r[9:6]), 4'(r[13:10]),
                 {r[31:24], 7'(r[22:16]), 1'b0}, $urandom & 32'hFFFF_FFFE,
                 $urandom & 32'hFFFF_FFFE);
        end
        report();
    end
endmodule